// File: doc/BRIEF.md
# Block Transfer Sequencer

This block runs a block copy between a host memory of 16-bit words and a remote memory of 40-bit words. It moves one remote word at a time through a single-word access engine, which it reaches over a request/acknowledge port, and it reaches the host memory through a synchronous RAM port with one cycle of read latency. A transfer is set up by one start pulse. The start carries the mode, the remote address, the host address and the word count.

The remote address is 20 bits wide and arrives as two 16-bit words. The high word holds bits 19..4. The low word holds the last four bits in its top nibble, and its lower 12 bits are carried through unchanged. After each word the block steps the address, moves the host pointer by the mode's stride and decrements the count. Between words it checks three reasons to stop. A count of zero ends the transfer with success. A nonzero accumulated error code ends it with that code. A pending interrupt ends it with no error code and raises a restart flag. In every case the address, host pointer and count it returns describe the first word not yet moved, so an interrupted transfer can be issued again with them and continue where it stopped.

Top module: `blkx_seq`

## Requirements
- R1: The mode selects the host stride per remote word. Mode 0 repeats one 40-bit value into successive remote words and does not advance the host pointer. Modes 1 (fetch) and 2 (store) use 2 host words per remote word. Modes 3 (fetch) and 4 (store) use 3 host words per remote word.
- R2: A remote word maps onto host words as follows. Host word 0 holds bits 39..24, word 1 holds bits 23..8, and bits 7..0 of word 2 hold bits 7..0. A 40-bit fetch writes zero into bits 15..8 of word 2, and a store ignores those bits.
- R3: A 32-bit store sends zero in remote bits 7..0. A 32-bit fetch writes only 2 host words per remote word and leaves the next host word untouched.
- R4: The engine address is {high word, low word bits 15..12}. After each word, 1 is added at bit 12 of the low word. A carry out of the low word increments the high word, and the 20-bit address wraps. Low-word bits 11..0 are preserved.
- R5: The count drops by one after each word. A transfer that completes reports error code 0, count 0 and a one-cycle done pulse.
- R6: Error codes returned with engine acknowledges are OR-ed together. After a word that returned a nonzero code the transfer stops, and it reports that code with the remaining count and the advanced addresses. No further remote word is accessed.
- R7: An interrupt pending after a word, with no error and a nonzero count left, stops the transfer with error code 0 and restart set. A word in flight always completes first. If the count reaches zero or an error is present, the transfer ends without restart.
- R8: A start with count 0 gives done on the next cycle with error code 0 and performs no host or engine access.
- R9: A start with mode 5, 6 or 7 completes with error code 8, performs no access and leaves the address and count inputs unchanged at the outputs.
- R10: A start pulse while a transfer is in progress is ignored.
- R11: The engine request stays high, with address and write data stable, until it is acknowledged. The host port is never used while an engine request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (taken only when idle) |
| mode_in | input | 3 | Transfer mode, encoding per R1 |
| rhi_in | input | 16 | Remote address high word |
| rlo_in | input | 16 | Remote address low word, low bits left-justified |
| host_in | input | 16 | Host start address |
| count_in | input | 16 | Remote words to move |
| irq_pend | input | 1 | Interrupt pending, sampled between words |
| eng_req | output | 1 | Single-word engine request |
| eng_write | output | 1 | 1 for store, 0 for fetch |
| eng_addr | output | 20 | Remote word address |
| eng_wdata | output | 40 | Store data |
| eng_ack | input | 1 | Engine acknowledge, one cycle |
| eng_rdata | input | 40 | Fetch data, valid with acknowledge |
| eng_err | input | 4 | Error code, valid with acknowledge |
| hm_en | output | 1 | Host RAM access enable |
| hm_we | output | 1 | Host RAM write enable |
| hm_addr | output | 16 | Host RAM address |
| hm_wdata | output | 16 | Host RAM write data |
| hm_rdata | input | 16 | Host RAM read data, one cycle after enable |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| err_code | output | 4 | Final error code |
| restart | output | 1 | Stopped by interrupt; reissue to continue |
| rhi_out | output | 16 | Updated remote address high word |
| rlo_out | output | 16 | Updated remote address low word |
| host_out | output | 16 | Updated host address |
| count_out | output | 16 | Words remaining |

## Verification
The bench sweeps every mode over short counts from two start addresses. One address makes the nibble carry into the high word and the other wraps the whole 20-bit address. A stepper that added at bit 0, or that lost the carry, would return wrong address words and would store to the wrong remote locations. Errors and interrupts are injected on a middle word and on the last word, and once together. A design with the wrong stop priority or an off-by-one count would show a wrong restart flag, a wrong remaining count, or an extra remote word written after the stop. Zero-count and unsupported-mode starts are checked for any access at all. A second start while a transfer is running must leave the first transfer's results intact.

// File: rtl/blkx_pkg.sv
package blkx_pkg;

    typedef enum logic [2:0] {
        M_REPL = 3'd0,
        M_F32  = 3'd1,
        M_S32  = 3'd2,
        M_F40  = 3'd3,
        M_S40  = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_RD   = 3'd1,
        S_RDC  = 3'd2,
        S_ENG  = 3'd3,
        S_WR   = 3'd4,
        S_STEP = 3'd5,
        S_FIN  = 3'd6
    } state_e;

    localparam logic [3:0] ERR_UNIMP = 4'h8;
    localparam logic [2:0] MODE_LAST = 3'd4;

    function automatic logic is_fetch(input mode_e m);
        return (m == M_F32) || (m == M_F40);
    endfunction

    // host words touched per remote word
    function automatic logic [1:0] host_span(input mode_e m);
        return ((m == M_F32) || (m == M_S32)) ? 2'd2 : 2'd3;
    endfunction

    // host pointer advance per remote word
    function automatic logic [1:0] host_stride(input mode_e m);
        case (m)
            M_F32, M_S32: return 2'd2;
            M_F40, M_S40: return 2'd3;
            default:      return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/blkx_addr_step.sv
module blkx_addr_step #(
    parameter int HI_W = 16,
    parameter int LO_W = 16,
    parameter int NIB  = 4
) (
    input  logic [HI_W-1:0]     hi_i,
    input  logic [LO_W-1:0]     lo_i,
    output logic [HI_W-1:0]     hi_o,
    output logic [LO_W-1:0]     lo_o,
    output logic [HI_W+NIB-1:0] flat_o
);
    localparam int SH = LO_W - NIB;

    logic [LO_W:0] sum;

    always_comb begin
        sum    = {1'b0, lo_i} + ({{LO_W{1'b0}}, 1'b1} << SH);
        lo_o   = sum[LO_W-1:0];
        hi_o   = hi_i + {{(HI_W-1){1'b0}}, sum[LO_W]};
        flat_o = {hi_i, lo_i[LO_W-1 -: NIB]};
    end

endmodule

// File: rtl/blkx_lanes.sv
module blkx_lanes #(
    parameter int HW = 16,
    parameter int DW = 40
) (
    input  logic [DW-1:0] data_i,
    input  logic [1:0]    sel_i,
    input  logic [HW-1:0] word_i,
    output logic [HW-1:0] word_o,
    output logic [DW-1:0] merged_o
);
    localparam int TAIL  = DW - 2*HW;
    localparam int NLANE = 3;

    logic [HW-1:0] lane [NLANE];

    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_full
            assign lane[g] = data_i[DW-1-g*HW -: HW];
        end
    endgenerate
    assign lane[2] = {{(HW-TAIL){1'b0}}, data_i[TAIL-1:0]};

    always_comb begin
        word_o   = lane[2];
        merged_o = data_i;
        case (sel_i)
            2'd0: begin
                word_o = lane[0];
                merged_o[DW-1 -: HW] = word_i;
            end
            2'd1: begin
                word_o = lane[1];
                merged_o[DW-HW-1 -: HW] = word_i;
            end
            default: begin
                merged_o[TAIL-1:0] = word_i[TAIL-1:0];
            end
        endcase
    end

endmodule

// File: rtl/blkx_seq.sv
module blkx_seq
    import blkx_pkg::*;
#(
    parameter int HW   = 16,
    parameter int CW   = 16,
    parameter int HI_W = 16,
    parameter int NIB  = 4,
    parameter int DW   = 40,
    parameter int EW   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [2:0]          mode_in,
    input  logic [HI_W-1:0]     rhi_in,
    input  logic [HW-1:0]       rlo_in,
    input  logic [HW-1:0]       host_in,
    input  logic [CW-1:0]       count_in,
    input  logic                irq_pend,
    output logic                eng_req,
    output logic                eng_write,
    output logic [HI_W+NIB-1:0] eng_addr,
    output logic [DW-1:0]       eng_wdata,
    input  logic                eng_ack,
    input  logic [DW-1:0]       eng_rdata,
    input  logic [EW-1:0]       eng_err,
    output logic                hm_en,
    output logic                hm_we,
    output logic [HW-1:0]       hm_addr,
    output logic [HW-1:0]       hm_wdata,
    input  logic [HW-1:0]       hm_rdata,
    output logic                done,
    output logic                busy,
    output logic [EW-1:0]       err_code,
    output logic                restart,
    output logic [HI_W-1:0]     rhi_out,
    output logic [HW-1:0]       rlo_out,
    output logic [HW-1:0]       host_out,
    output logic [CW-1:0]       count_out
);
    localparam int RAW = HI_W + NIB;

    typedef struct packed {
        state_e          st;
        logic [1:0]      idx;
        mode_e           mode;
        logic [HI_W-1:0] rhi;
        logic [HW-1:0]   rlo;
        logic [HW-1:0]   host;
        logic [CW-1:0]   cnt;
        logic [DW-1:0]   data;
        logic [EW-1:0]   err;
        logic            restart;
    } ctl_t;

    ctl_t q, d;

    logic [HI_W-1:0] hi_nx;
    logic [HW-1:0]   lo_nx;
    logic [RAW-1:0]  flat;
    logic [HW-1:0]   lane_word;
    logic [DW-1:0]   lane_merged;
    logic [1:0]      span;
    logic [HW-1:0]   stride;
    logic            fetch;
    logic            last_lane;

    blkx_addr_step #(.HI_W(HI_W), .LO_W(HW), .NIB(NIB)) u_step (
        .hi_i   (q.rhi),
        .lo_i   (q.rlo),
        .hi_o   (hi_nx),
        .lo_o   (lo_nx),
        .flat_o (flat)
    );

    blkx_lanes #(.HW(HW), .DW(DW)) u_lanes (
        .data_i   (q.data),
        .sel_i    (q.idx),
        .word_i   (hm_rdata),
        .word_o   (lane_word),
        .merged_o (lane_merged)
    );

    always_comb begin
        span      = host_span(q.mode);
        stride    = {{(HW-2){1'b0}}, host_stride(q.mode)};
        fetch     = is_fetch(q.mode);
        last_lane = (q.idx == span - 2'd1);
    end

    always_comb begin
        d       = q;
        hm_en   = 1'b0;
        hm_we   = 1'b0;
        eng_req = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (start) begin
                    d.mode    = mode_e'(mode_in);
                    d.rhi     = rhi_in;
                    d.rlo     = rlo_in;
                    d.host    = host_in;
                    d.cnt     = count_in;
                    d.err     = '0;
                    d.restart = 1'b0;
                    d.idx     = 2'd0;
                    d.data    = '0;
                    if (mode_in > MODE_LAST) begin
                        d.err = EW'(ERR_UNIMP);
                        d.st  = S_FIN;
                    end else if (count_in == '0) begin
                        d.st = S_FIN;
                    end else if (is_fetch(mode_e'(mode_in))) begin
                        d.st = S_ENG;
                    end else begin
                        d.st = S_RD;
                    end
                end
            end
            S_RD: begin
                hm_en = 1'b1;
                d.st  = S_RDC;
            end
            S_RDC: begin
                d.data = lane_merged;
                if (last_lane) begin
                    d.idx = 2'd0;
                    d.st  = S_ENG;
                end else begin
                    d.idx = q.idx + 2'd1;
                    d.st  = S_RD;
                end
            end
            S_ENG: begin
                eng_req = 1'b1;
                if (eng_ack) begin
                    d.err = q.err | eng_err;
                    if (fetch) begin
                        d.data = eng_rdata;
                        d.idx  = 2'd0;
                        d.st   = S_WR;
                    end else begin
                        d.st = S_STEP;
                    end
                end
            end
            S_WR: begin
                hm_en = 1'b1;
                hm_we = 1'b1;
                if (last_lane) begin
                    d.idx = 2'd0;
                    d.st  = S_STEP;
                end else begin
                    d.idx = q.idx + 2'd1;
                end
            end
            S_STEP: begin
                d.host = q.host + stride;
                d.rhi  = hi_nx;
                d.rlo  = lo_nx;
                d.cnt  = q.cnt - CW'(1);
                d.idx  = 2'd0;
                if (q.cnt == CW'(1)) begin
                    d.st = S_FIN;
                end else if (q.err != '0) begin
                    d.st = S_FIN;
                end else if (irq_pend) begin
                    d.restart = 1'b1;
                    d.st      = S_FIN;
                end else begin
                    d.st = fetch ? S_ENG : S_RD;
                end
            end
            S_FIN: d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign hm_addr   = q.host + {{(HW-2){1'b0}}, q.idx};
    assign hm_wdata  = lane_word;
    assign eng_write = ~fetch;
    assign eng_addr  = flat;
    assign eng_wdata = q.data;
    assign done      = (q.st == S_FIN);
    assign busy      = (q.st != S_IDLE);
    assign err_code  = q.err;
    assign restart   = q.restart;
    assign rhi_out   = q.rhi;
    assign rlo_out   = q.rlo;
    assign host_out  = q.host;
    assign count_out = q.cnt;

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && !eng_ack) |=> (eng_req && $stable(eng_addr) && $stable(eng_wdata)));

    assert_port_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hm_en && eng_req));

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((count_out == $past(count_out)) || (count_out == $past(count_out) - CW'(1))));

    assert_restart_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && restart) |-> (err_code == '0));

    assert_repl_host_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.mode == M_REPL) |=> $stable(host_out));

    assert_zero_noaccess_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && count_in == '0) |=> (done && !eng_req && !hm_en));

endmodule

// File: tb/sim_blkx_seq.sv
module sim_blkx_seq;
    localparam int CLK_NS = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_NS/2) clk = ~clk;

    logic        start = 1'b0;
    logic [2:0]  mode_in = '0;
    logic [15:0] rhi_in = '0, rlo_in = '0, host_in = '0, count_in = '0;
    logic        irq_pend = 1'b0;
    logic        eng_req, eng_write, eng_ack = 1'b0;
    logic [19:0] eng_addr;
    logic [39:0] eng_wdata, eng_rdata = '0;
    logic [3:0]  eng_err = '0;
    logic        hm_en, hm_we;
    logic [15:0] hm_addr, hm_wdata, hm_rdata = '0;
    logic        done, busy, restart;
    logic [3:0]  err_code;
    logic [15:0] rhi_out, rlo_out, host_out, count_out;

    blkx_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_in),
        .rhi_in(rhi_in), .rlo_in(rlo_in), .host_in(host_in), .count_in(count_in),
        .irq_pend(irq_pend), .eng_req(eng_req), .eng_write(eng_write),
        .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_ack(eng_ack),
        .eng_rdata(eng_rdata), .eng_err(eng_err), .hm_en(hm_en), .hm_we(hm_we),
        .hm_addr(hm_addr), .hm_wdata(hm_wdata), .hm_rdata(hm_rdata),
        .done(done), .busy(busy), .err_code(err_code), .restart(restart),
        .rhi_out(rhi_out), .rlo_out(rlo_out), .host_out(host_out), .count_out(count_out)
    );

    int nchk = 0, nerr = 0;
    logic        hinit = 1'b0;
    int          err_at = -1, irq_at = -1;
    logic [3:0]  err_val = '0;
    int          lat = 0, widx = 0, acc = 0;
    logic [15:0] hmem [0:1023];
    logic [39:0] rmem [logic [19:0]];

    function automatic logic [15:0] hp(input logic [15:0] a);
        return 16'((32'(a) * 32'h2D1) ^ 32'hB4E7);
    endfunction

    function automatic logic [39:0] rpat(input logic [19:0] a);
        return {a ^ 20'h5A5A5, 20'(a * 20'h3B1) ^ 20'h00C0F};
    endfunction

    function automatic logic [39:0] rrd(input logic [19:0] a);
        if (rmem.exists(a)) return rmem[a];
        return rpat(a);
    endfunction

    // host RAM model
    always @(posedge clk) begin
        if (hinit) begin
            for (int i = 0; i < 1024; i++) hmem[i] <= hp(16'(i));
        end else if (hm_en) begin
            if (hm_we) hmem[hm_addr[9:0]] <= hm_wdata;
            hm_rdata <= hmem[hm_addr[9:0]];
        end
    end

    // single-word engine model, 3-cycle latency
    always @(posedge clk) begin
        eng_ack <= 1'b0;
        eng_err <= '0;
        if (hinit) begin
            rmem.delete();
            widx     <= 0;
            lat      <= 0;
            irq_pend <= 1'b0;
        end else if (eng_req && !eng_ack) begin
            if (lat == 2) begin
                lat       <= 0;
                eng_ack   <= 1'b1;
                eng_rdata <= rrd(eng_addr);
                if (eng_write) rmem[eng_addr] = eng_wdata;
                if (widx == err_at) eng_err <= err_val;
                if (widx == irq_at) irq_pend <= 1'b1;
                widx <= widx + 1;
            end else begin
                lat <= lat + 1;
            end
        end
    end

    always @(posedge clk) begin
        if (hinit) acc <= 0;
        else if (hm_en || eng_req) acc <= acc + 1;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic prep(input int ea, input int ia, input logic [3:0] ev);
        @(negedge clk);
        err_at = ea; irq_at = ia; err_val = ev;
        hinit = 1'b1;
        @(negedge clk);
        hinit = 1'b0;
    endtask

    task automatic launch(input logic [2:0] m, input logic [15:0] hi, input logic [15:0] lo,
                          input logic [15:0] h, input logic [15:0] n);
        @(negedge clk);
        mode_in = m; rhi_in = hi; rlo_in = lo; host_in = h; count_in = n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int t = 0;
        while (!done && t < 3000) begin
            @(negedge clk);
            t++;
        end
        chk("R5 done pulse seen", {63'd0, done}, 64'd1);
    endtask

    function automatic int stride_of(input logic [2:0] m);
        case (m)
            3'd1, 3'd2: return 2;
            3'd3, 3'd4: return 3;
            default:    return 0;
        endcase
    endfunction

    // outputs sampled at the done cycle; k = words moved
    task automatic verify(input logic [2:0] m, input logic [15:0] hi, input logic [15:0] lo,
                          input logic [15:0] h, input logic [15:0] n, input int k,
                          input logic [3:0] err, input logic rs);
        logic [19:0] a0, af, a;
        logic [15:0] hb;
        logic [39:0] r, ex;
        int s;
        s  = stride_of(m);
        a0 = {hi, lo[15:12]};
        af = a0 + 20'(k);
        chk("R5/R6 error code", 64'(err_code), 64'(err));
        chk("R7 restart flag", 64'(restart), 64'(rs));
        chk("R4 remote high word", 64'(rhi_out), 64'(af[19:4]));
        chk("R4 remote low word", 64'(rlo_out), 64'({af[3:0], lo[11:0]}));
        chk("R1 host address", 64'(host_out), 64'(16'(h + 16'(s * k))));
        chk("R5 remaining count", 64'(count_out), 64'(16'(n - 16'(k))));
        for (int i = 0; i < k; i++) begin
            a  = a0 + 20'(i);
            hb = 16'(h + 16'(s * i));
            if (m == 3'd0 || m == 3'd2 || m == 3'd4) begin
                ex = {hp(hb), hp(16'(hb + 1)), (m == 3'd2) ? 8'h00 : hp(16'(hb + 2))[7:0]};
                chk((m == 3'd2) ? "R3 store32 word" : "R1/R2 store word", rrd(a), ex);
            end else begin
                r = rpat(a);
                chk("R2 fetch host word 0", 64'(hmem[hb[9:0]]), 64'(r[39:24]));
                chk("R2 fetch host word 1", 64'(hmem[10'(hb + 1)]), 64'(r[23:8]));
                if (m == 3'd3)
                    chk("R2 fetch host word 2", 64'(hmem[10'(hb + 2)]), 64'({8'h00, r[7:0]}));
            end
        end
        if (m == 3'd1 && k > 0) begin
            hb = 16'(h + 16'(2 * k));
            chk("R3 fetch32 leaves next host word", 64'(hmem[hb[9:0]]), 64'(hp(hb)));
        end
        if (m == 3'd0 || m == 3'd2 || m == 3'd4)
            chk("R6 no remote write past stop", 64'(rmem.exists(af)), 64'd0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [15:0] hi, lo, n, h;
        repeat (3) @(negedge clk);
        chk("R5 reset done", {63'd0, done}, 64'd0);
        chk("R5 reset busy", {63'd0, busy}, 64'd0);
        chk("R11 reset engine request", {63'd0, eng_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R5 reset count", 64'(count_out), 64'd0);
        chk("R7 reset restart", 64'(restart), 64'd0);
        chk("R11 idle host port", {63'd0, hm_en}, 64'd0);

        // sweep: all modes, short counts, carry and wrap addresses
        for (int m = 0; m < 5; m++) begin
            for (int ci = 0; ci < 4; ci++) begin
                for (int ai = 0; ai < 2; ai++) begin
                    n  = (ci == 3) ? 16'd4 : 16'(ci);
                    hi = (ai == 0) ? 16'h12FF : 16'hFFFF;
                    lo = (ai == 0) ? 16'hE123 : 16'hF0A5;
                    h  = 16'(16'h0040 + 16'(m * 24));
                    prep(-1, -1, 4'h0);
                    launch(3'(m), hi, lo, h, n);
                    wait_done();
                    verify(3'(m), hi, lo, h, n, int'(n), 4'h0, 1'b0);
                    if (n == 0) chk("R8 zero count no access", 64'(acc), 64'd0);
                end
            end
        end

        // error mid-transfer
        prep(1, -1, 4'h1);
        launch(3'd4, 16'h0100, 16'hE000, 16'h0080, 16'd5);
        wait_done();
        verify(3'd4, 16'h0100, 16'hE000, 16'h0080, 16'd5, 2, 4'h1, 1'b0);

        // error on last word: count zero, error still reported
        prep(1, -1, 4'h2);
        launch(3'd1, 16'h0200, 16'h3000, 16'h0100, 16'd2);
        wait_done();
        verify(3'd1, 16'h0200, 16'h3000, 16'h0100, 16'd2, 2, 4'h2, 1'b0);

        // interrupt mid-transfer, then resume from outputs
        prep(-1, 2, 4'h0);
        launch(3'd1, 16'h0033, 16'hF777, 16'h0100, 16'd6);
        wait_done();
        verify(3'd1, 16'h0033, 16'hF777, 16'h0100, 16'd6, 3, 4'h0, 1'b1);
        hi = rhi_out; lo = rlo_out; h = host_out; n = count_out;
        prep(-1, -1, 4'h0);
        launch(3'd1, hi, lo, h, n);
        wait_done();
        verify(3'd1, hi, lo, h, n, 3, 4'h0, 1'b0);

        // interrupt on last word: normal finish
        prep(-1, 2, 4'h0);
        launch(3'd0, 16'h0400, 16'h1000, 16'h0200, 16'd3);
        wait_done();
        verify(3'd0, 16'h0400, 16'h1000, 16'h0200, 16'd3, 3, 4'h0, 1'b0);

        // error and interrupt on same word: error wins
        prep(1, 1, 4'h4);
        launch(3'd3, 16'h0500, 16'hF000, 16'h0120, 16'd4);
        wait_done();
        verify(3'd3, 16'h0500, 16'hF000, 16'h0120, 16'd4, 2, 4'h4, 1'b0);

        // unsupported mode
        prep(-1, -1, 4'h0);
        launch(3'd6, 16'h0600, 16'h2000, 16'h0140, 16'd5);
        wait_done();
        verify(3'd6, 16'h0600, 16'h2000, 16'h0140, 16'd5, 0, 4'h8, 1'b0);
        chk("R9 unsupported mode no access", 64'(acc), 64'd0);

        // second start while busy is ignored
        prep(-1, -1, 4'h0);
        launch(3'd4, 16'h0700, 16'hC000, 16'h0160, 16'd3);
        repeat (4) @(negedge clk);
        mode_in = 3'd1; rhi_in = 16'h0900; rlo_in = 16'h0000; host_in = 16'h0300; count_in = 16'd9;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        verify(3'd4, 16'h0700, 16'hC000, 16'h0160, 16'd3, 3, 4'h0, 1'b0);
        chk("R10 engine words issued", 64'(widx), 64'd3);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule